// File: doc/BRIEF.md
# Capture Timer with Interval Events

The block keeps a 32-bit free-running up-counter. A prescaler supplies a one-cycle `tick` strobe, and the counter advances once per tick. Four capture channels watch four external pins. When a pin shows the edge its channel is set for, that channel copies the counter into its capture register. The last channel can instead be fed by an on-chip compare-match strobe. Each capture sets a sticky flag. The flag then drives either a DMA request line or the shared interrupt line, depending on a routing bit.

Eight interval taps watch counter bits 6 to 13. A tap fires whenever its bit steps from 0 to 1 as the counter advances. A firing tap sets a sticky interval flag, and it can also issue a one-cycle converter-start pulse on its own trigger line. Software uses a small word-wide register port. Through it, software presets the counter, reads the captures, sets edge modes, routing and enables, and clears flags by writing ones.

Top module: `cap_timer`

## Requirements
- R1: At each clock with `tick` high, the counter (address 0) becomes its old value plus one. Without `tick` it holds. A write to address 0 loads `wdata` and takes priority over counting.
- R2: When an enabled increment takes the counter from all ones to zero, the overflow flag (status bit 4) is set.
- R3: Pins pass through two flops, and edges are found by comparing the second flop with a third. A pin level that a clock edge first samples loads the channel's capture register (addresses 1 to 4) at the second clock edge after it. The value loaded is the counter value held just before that edge.
- R4: Config bits [2i+1:2i] set the edge mode of channel i: 00 off, 01 rising, 10 falling, 11 both. A channel set to off never captures from its pin.
- R5: While config bit 8 is set, channel 3 ignores its pin and captures on the clock edge where `alt_strobe` is high, whatever its edge mode.
- R6: Config bit 12+i set routes channel i's flag to `dma_req[i]`, and the flag is then kept off the interrupt. With the bit clear, `dma_req[i]` stays low.
- R7: Status (address 6) holds capture flags in [3:0], overflow in bit 4 and interval flags in [15:8]. Writing 1 to a bit clears it. A new event in the same cycle wins over the clear.
- R8: An increment that takes counter bit 6+j from 0 to 1 sets status bit 8+j.
- R9: That same increment gives a one-cycle pulse on `adc_trig[j]` in the following cycle, provided bit j of the converter-enable register (address 8) is set.
- R10: `irq` is high while any status bit is set whose matching bit in the interrupt-enable register (address 7) is set, apart from capture flags routed to DMA.
- R11: After reset the counter, captures, configuration, enables and flags all read zero, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| cap_pin | input | 4 | Asynchronous capture pins |
| alt_strobe | input | 1 | Synchronous compare-match strobe for channel 3 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |
| dma_req | output | 4 | Per-channel DMA request level |
| adc_trig | output | 8 | Per-tap converter-start pulses |

## Verification
A reference model steps alongside the design, and every register read, `irq`, `dma_req` and `adc_trig` are compared with it on every clock. The pins are driven with single transitions, with pulses in both directions and with pulses made while a channel is off. These show whether the edge filter picks the right direction and whether the two-stage delay lands the capture on the right count. The alternate strobe is fired while the channel-3 pin toggles, which shows whether the strobe path replaces the pin path. A long unbroken count run with all taps enabled, plus presets just below tap boundaries and just below wrap, tells correct 0-to-1 detection apart from level or any-change detection.

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int CW     = 32,
  parameter int NCAP   = 4,
  parameter int TAP_LO = 6,
  parameter int NTAP   = 8,
  parameter int AW     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [NCAP-1:0] cap_pin,
  input  logic            alt_strobe,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [CW-1:0]   wdata,
  output logic [CW-1:0]   rdata,
  output logic            irq,
  output logic [NCAP-1:0] dma_req,
  output logic [NTAP-1:0] adc_trig
);
  localparam int ALT  = 2*NCAP;
  localparam int RLO  = ALT + 4;
  localparam int CFGW = RLO + NCAP;
  localparam int ILO  = 8;
  localparam int SW   = ILO + NTAP;
  localparam int A_CFG = NCAP + 1;
  localparam int A_ST  = NCAP + 2;
  localparam int A_IEN = NCAP + 3;
  localparam int A_AEN = NCAP + 4;

  logic [CW-1:0]   cnt;
  logic [CW-1:0]   cap [NCAP];
  logic [NCAP-1:0] s1, s2, s3, hit;
  logic [CFGW-1:0] cfg;
  logic [NCAP-1:0] cflag;
  logic            oflag;
  logic [NTAP-1:0] iflag, aen, evt;
  logic [SW-1:0]   ien, stat, clr;
  logic            wr_cnt, adv, ovf_evt;

  assign wr_cnt  = wr_en && addr == AW'(0);
  assign adv     = tick && !wr_cnt;
  assign ovf_evt = adv && (&cnt);
  assign clr     = (wr_en && addr == AW'(A_ST)) ? wdata[SW-1:0] : '0;

  for (genvar j = 0; j < NTAP; j++) begin : g_tap
    assign evt[j] = adv && (&cnt[TAP_LO+j-1:0]) && !cnt[TAP_LO+j];
  end

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    logic pin_hit;
    assign pin_hit = (cfg[2*i] && s2[i] && !s3[i]) || (cfg[2*i+1] && !s2[i] && s3[i]);
    if (i == NCAP-1) begin : g_alt
      assign hit[i] = cfg[ALT] ? alt_strobe : pin_hit;
    end else begin : g_pin
      assign hit[i] = pin_hit;
    end
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cap[i] <= '0;
      else if (hit[i]) cap[i] <= cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; s1 <= '0; s2 <= '0; s3 <= '0;
      cfg <= '0; ien <= '0; aen <= '0;
      cflag <= '0; oflag <= 1'b0; iflag <= '0; adc_trig <= '0;
    end else begin
      if (wr_cnt)   cnt <= wdata;
      else if (tick) cnt <= cnt + CW'(1);
      s1 <= cap_pin; s2 <= s1; s3 <= s2;
      if (wr_en && addr == AW'(A_CFG)) cfg <= wdata[CFGW-1:0];
      if (wr_en && addr == AW'(A_IEN)) ien <= wdata[SW-1:0];
      if (wr_en && addr == AW'(A_AEN)) aen <= wdata[NTAP-1:0];
      cflag    <= (cflag & ~clr[NCAP-1:0]) | hit;
      oflag    <= (oflag & ~clr[NCAP]) | ovf_evt;
      iflag    <= (iflag & ~clr[ILO +: NTAP]) | evt;
      adc_trig <= evt & aen;
    end
  end

  assign stat    = {iflag, {(ILO-NCAP-1){1'b0}}, oflag, cflag};
  assign dma_req = cflag & cfg[RLO +: NCAP];
  assign irq     = |(stat & ien & ~SW'(dma_req));

  always_comb begin
    rdata = '0;
    if (addr == AW'(0)) rdata = cnt;
    else if (int'(addr) <= NCAP) rdata = cap[int'(addr)-1];
    else if (addr == AW'(A_CFG)) rdata = CW'(cfg);
    else if (addr == AW'(A_ST))  rdata = CW'(stat);
    else if (addr == AW'(A_IEN)) rdata = CW'(ien);
    else if (addr == AW'(A_AEN)) rdata = CW'(aen);
  end
endmodule

module cap_timer_chk #(
  parameter int CW = 32, parameter int NTAP = 8, parameter int AW = 4
) (
  input logic clk, rst_n, tick, wr_en, alt_strobe, alt_sel, oflag,
  input logic [AW-1:0]   addr,
  input logic [CW-1:0]   cnt, cap_last,
  input logic [NTAP-1:0] adc_trig
);
  logic wrc;
  assign wrc = wr_en && addr == AW'(0);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wrc |=> cnt == $past(cnt) + CW'(1)); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wrc |=> $stable(cnt)); // R1
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wrc && (&cnt) |=> oflag && cnt == '0); // R2
  AST_ALT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    alt_sel && alt_strobe |=> cap_last == $past(cnt)); // R5
  AST_ADC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|adc_trig) |=> (adc_trig & $past(adc_trig)) == '0); // R9
endmodule

bind cap_timer cap_timer_chk #(.CW(CW), .NTAP(NTAP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .alt_strobe(alt_strobe),
  .alt_sel(cfg[ALT]), .oflag(oflag), .addr(addr), .cnt(cnt),
  .cap_last(cap[NCAP-1]), .adc_trig(adc_trig));

// File: tb/cap_timer_test.sv
module cap_timer_test;
  logic clk = 0, rst_n = 0, tick = 0, alt_strobe = 0, wr_en = 0;
  logic [3:0] cap_pin = 0, addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  logic [3:0] dma_req;
  logic [7:0] adc_trig;
  int checks = 0, fails = 0;
  bit started = 0, done = 0;
  string phase = "R11";

  always #10 clk = ~clk;

  cap_timer uut (.clk, .rst_n, .tick, .cap_pin, .alt_strobe, .wr_en, .addr,
                 .wdata, .rdata, .irq, .dma_req, .adc_trig);

  // reference model
  logic [31:0] m_cnt, m_cap [4];
  logic [3:0]  h1, h2, h3, m_cf;
  logic [15:0] m_cfg, m_ien;
  logic [7:0]  m_if, m_aen, m_adc;
  logic        m_of;

  function automatic logic [15:0] m_stat();
    return {m_if, 3'b000, m_of, m_cf};
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      0: return m_cnt;
      1, 2, 3, 4: return m_cap[a-1];
      5: return {16'h0, m_cfg};
      6: return {16'h0, m_stat()};
      7: return {16'h0, m_ien};
      8: return {24'h0, m_aen};
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      m_cnt = 0; h1 = 0; h2 = 0; h3 = 0; m_cf = 0; m_cfg = 0; m_ien = 0;
      m_if = 0; m_aen = 0; m_adc = 0; m_of = 0;
      for (int i = 0; i < 4; i++) m_cap[i] = 0;
    end else begin
      logic [31:0] nxt;
      logic [3:0] hits;
      logic [7:0] ev;
      logic [15:0] clr;
      bit counted;
      counted = tick && !(wr_en && addr == 0);
      nxt = counted ? m_cnt + 1 : m_cnt;
      ev = 0;
      for (int j = 0; j < 8; j++)
        if (counted && m_cnt[6+j] == 0 && nxt[6+j] == 1) ev[j] = 1;
      for (int i = 0; i < 4; i++) begin
        int md;
        md = m_cfg[2*i +: 2];
        hits[i] = ((md == 1 || md == 3) && h2[i] && !h3[i]) ||
                  ((md == 2 || md == 3) && !h2[i] && h3[i]);
      end
      if (m_cfg[8]) hits[3] = alt_strobe;
      for (int i = 0; i < 4; i++) if (hits[i]) m_cap[i] = m_cnt;
      clr = (wr_en && addr == 6) ? wdata[15:0] : 16'h0;
      m_cf = (m_cf & ~clr[3:0]) | hits;
      m_of = (m_of & !clr[4]) | (counted && m_cnt == 32'hFFFF_FFFF);
      m_if = (m_if & ~clr[15:8]) | ev;
      m_adc = ev & m_aen;
      if (wr_en && addr == 5) m_cfg = wdata[15:0];
      if (wr_en && addr == 7) m_ien = wdata[15:0];
      if (wr_en && addr == 8) m_aen = wdata[7:0];
      m_cnt = (wr_en && addr == 0) ? wdata : nxt;
      h3 = h2; h2 = h1; h1 = cap_pin;
    end
  end

  function automatic string rreq(input logic [3:0] a);
    case (a)
      0: return "R1";
      1, 2, 3, 4: return "R3";
      6: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, phase, $time, act, exp_v);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    logic [15:0] mirq;
    mirq = m_stat() & m_ien & ~{12'h0, m_cf & m_cfg[15:12]};
    chk(rreq(addr), rdata, m_read(addr));
    chk("R10", {31'h0, irq}, {31'h0, |mirq});
    chk("R6", {28'h0, dma_req}, {28'h0, m_cf & m_cfg[15:12]});
    chk("R9", {24'h0, adc_trig}, {24'h0, m_adc});
  end

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d; step(); wr_en = 0;
  endtask

  initial begin
    #(20 * 190000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(3); rst_n = 1;
    phase = "R11";
    for (int a = 0; a <= 8; a++) begin addr = 4'(a); step(); end
    phase = "R1";
    addr = 0; tick = 1; step(10); tick = 0; step(5);
    wr(0, 32'd100); tick = 1; step(4);
    wr_en = 1; wdata = 32'd7; step(); wr_en = 0; step(2);
    phase = "R4";
    wr(5, 32'h0000_0036);
    wr(7, 32'h0000_FF1F);
    for (int p = 0; p < 6; p++) begin
      cap_pin = cap_pin ^ 4'b1111; step(5);
      for (int a = 1; a <= 6; a++) begin addr = 4'(a); step(); end
    end
    cap_pin[0] = 1; step(); cap_pin[0] = 0; step(4);
    phase = "R7";
    wr(6, 32'h0000_0005); addr = 6; step(2);
    cap_pin = cap_pin ^ 4'b0001; step(1);
    wr(6, 32'h0000_0001); step(3); wr(6, 32'hFFFF); step(2);
    phase = "R6";
    wr(5, 32'h0000_A0FF); addr = 6;
    for (int p = 0; p < 4; p++) begin cap_pin = cap_pin ^ 4'b1111; step(6); end
    wr(6, 32'h000F); step(2);
    phase = "R5";
    wr(5, 32'h0000_013F); addr = 4;
    for (int p = 0; p < 3; p++) begin
      cap_pin[3] = ~cap_pin[3]; step(6);
      alt_strobe = 1; step(); alt_strobe = 0; step(3);
    end
    wr(5, 32'h0000_00C0); cap_pin[3] = ~cap_pin[3]; step(6);
    phase = "R8";
    wr(8, 32'h0000_00A5); wr(0, 32'h0000_003E); addr = 6; step(4);
    wr(0, 32'h0000_3FFD); step(6);
    wr(8, 32'h0000_00FF); wr(6, 32'hFFFF); wr(0, 0); addr = 6;
    for (int k = 0; k < 17000; k++) begin
      step();
      if (k % 1000 == 999) wr(6, 32'hFF00);
    end
    phase = "R2";
    wr(0, 32'hFFFF_FFFC); addr = 6; step(8);
    addr = 0; step(2); tick = 0; addr = 6;
    wr(6, 32'h0010); step(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule